// File: doc/BRIEF.md
# Chroma-from-Luma Luma Downsampler

This block turns the reconstructed luma samples of one block into the scaled luma values that a chroma-from-luma predictor needs. The samples arrive one per cycle as a raster stream of luma rows. The block reduces them to chroma resolution in the way the chroma format requires, and it writes each result into a prediction buffer as an unsigned 16-bit word. The buffer has a fixed row pitch. Every format lands on the same scale of eight times a sample, which gives three fractional bits.

A block starts with a one-cycle `start` pulse while the block is idle. At that pulse the format code, the chroma (output) width and the luma row count are captured. The block then accepts luma samples through a valid/ready handshake and drives the buffer through a registered write port. It pulses `done` once the block has been written in full. When the configuration cannot be served, the block raises an error flag instead and performs no writes.

Top module: `cfl_luma_downsampler`

## Requirements
- R1: With format code 0, each output word is twice the sum of a 2x2 luma neighbourhood: luma columns 2c and 2c+1 of luma rows 2r and 2r+1. It is written as output row r, column c.
- R2: With format code 1, each output word is four times the sum of luma columns 2c and 2c+1 of one luma row r. It is written as output row r, column c.
- R3: With format code 2, each output word is eight times the luma sample at row r, column c. It is written as output row r, column c.
- R4: Output (r,c) is written to address r*32+c, whatever the width. Format code 0 yields half as many output rows as luma rows, and the other codes yield one output row per luma row. No other address is written.
- R5: `s_ready` is high only while a block is in progress, so a sample is taken on every cycle where `s_valid` and `s_ready` are both high. Idle cycles with `s_valid` low change no result. Once the last sample has been taken, `s_ready` falls.
- R6: `done` is a single-cycle pulse, asserted in the cycle right after the last buffer write of a block.
- R7: A start is rejected in any of these cases: format code 3, a width other than 4, 8, 16 or 32, a luma row count of zero, an odd luma row count with format code 0, or more than 32 output rows. On rejection, `err` rises and stays high until a start is accepted, `s_ready` stays low, and no write or `done` occurs.
- R8: Only the low 12 bits of `s_data` carry the sample, and bits 15..12 have no effect on any output word.
- R9: Full-scale 12-bit input gives output words of 32760 in every format, so bit 15 of a written word is always zero.
- R10: While reset is held and just after it, `wr_en`, `done`, `err` and `s_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a block; sampled only while idle |
| cfg_fmt | input | 2 | Format code: 0 = 4:2:0, 1 = 4:2:2, 2 = 4:4:4 |
| cfg_width | input | 6 | Output (chroma) width in samples |
| cfg_luma_rows | input | 7 | Number of luma rows in the block |
| s_valid | input | 1 | Luma sample present |
| s_ready | output | 1 | Block is taking samples |
| s_data | input | 16 | Luma sample container, low 12 bits used |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | 10 | Buffer word address, row*32+column |
| wr_data | output | 16 | Scaled luma value |
| done | output | 1 | Block finished pulse |
| err | output | 1 | Last start was rejected |

## Verification
The assertions rely on two properties of the stimulus. First, the configuration captured at `start` is the one in force while the block runs. Second, `start` matters only while the block is idle. Based on that, they check the low-bit pattern of written words for each format, the column range, and the ordering of writes, beats and `done`. The bench pulses `start` only between blocks and holds the configuration pins steady while a block is running. Luma rows are streamed in raster order, with valid-low gaps inserted in some runs. In some runs the container bits above the sample width are filled with nonzero junk.

// File: rtl/cfl_ds_pkg.sv
package cfl_ds_pkg;

  localparam int unsigned CFL_WORD_W = 16;

  typedef enum logic [1:0] {
    FMT_420 = 2'd0,
    FMT_422 = 2'd1,
    FMT_444 = 2'd2,
    FMT_BAD = 2'd3
  } cfmt_e;

  // Power of two between 4 and the buffer pitch.
  function automatic logic width_ok(input int unsigned w, input int unsigned max_w);
    return (w >= 4) && (w <= max_w) && ((w & (w - 1)) == 0);
  endfunction

  function automatic logic cfg_ok(input logic [1:0] fmt, input int unsigned w,
                                  input int unsigned h, input int unsigned max_w,
                                  input int unsigned max_rows);
    int unsigned orows;
    if (fmt == FMT_BAD) return 1'b0;
    if (!width_ok(w, max_w)) return 1'b0;
    if (h == 0) return 1'b0;
    if (fmt == FMT_420) begin
      if ((h % 2) != 0) return 1'b0;
      orows = h / 2;
    end else begin
      orows = h;
    end
    return orows <= max_rows;
  endfunction

  // Window sum to x8 scale: 4 taps need x2, 2 taps x4, 1 tap x8.
  function automatic logic [CFL_WORD_W-1:0] scale_word(input cfmt_e fmt,
                                                       input logic [CFL_WORD_W-1:0] v);
    case (fmt)
      FMT_420: return v << 1;
      FMT_422: return v << 2;
      default: return v << 3;
    endcase
  endfunction

endpackage

// File: rtl/cfl_ds_ctrl.sv
module cfl_ds_ctrl
  import cfl_ds_pkg::*;
#(
  parameter int unsigned MAX_OUT_W = 32,
  parameter int unsigned BUF_ROWS  = 32,
  parameter int unsigned WID_W     = 6,
  parameter int unsigned HGT_W     = 7,
  parameter int unsigned LCOL_W    = 6,
  parameter int unsigned LROW_W    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        cfg_fmt,
  input  logic [WID_W-1:0]  cfg_width,
  input  logic [HGT_W-1:0]  cfg_luma_rows,
  input  logic              s_valid,
  output logic              s_ready,
  output logic              beat,
  output logic              at_last,
  output logic [LCOL_W-1:0] lcol,
  output logic [LROW_W-1:0] lrow,
  output cfmt_e             fmt_q,
  output logic [WID_W-1:0]  width_q,
  output logic              err
);

  typedef enum logic {ST_IDLE, ST_RUN} st_e;
  st_e state;

  logic [LCOL_W-1:0] lw_m1;
  logic [LROW_W-1:0] lrows_m1;
  logic [WID_W:0]    lw;
  logic              cfg_good;
  logic              row_end;

  assign cfg_good = cfg_ok(cfg_fmt, 32'(cfg_width), 32'(cfg_luma_rows), MAX_OUT_W, BUF_ROWS);
  assign lw       = (cfg_fmt == FMT_444) ? {1'b0, cfg_width} : {cfg_width, 1'b0};

  assign s_ready  = (state == ST_RUN);
  assign beat     = s_ready && s_valid;
  assign row_end  = (lcol == lw_m1);
  assign at_last  = row_end && (lrow == lrows_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      fmt_q    <= FMT_420;
      width_q  <= '0;
      lw_m1    <= '0;
      lrows_m1 <= '0;
      lcol     <= '0;
      lrow     <= '0;
      err      <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (cfg_good) begin
              state    <= ST_RUN;
              fmt_q    <= cfmt_e'(cfg_fmt);
              width_q  <= cfg_width;
              lw_m1    <= LCOL_W'(lw - 1'b1);
              lrows_m1 <= LROW_W'(cfg_luma_rows - 1'b1);
              lcol     <= '0;
              lrow     <= '0;
              err      <= 1'b0;
            end else begin
              err <= 1'b1;
            end
          end
        end
        ST_RUN: begin
          if (beat) begin
            if (row_end) begin
              lcol <= '0;
              lrow <= lrow + 1'b1;
              if (at_last) state <= ST_IDLE;
            end else begin
              lcol <= lcol + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r7_err_blocks_ready: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !s_ready);

  a_r5_ready_falls_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && at_last) |=> !s_ready);

endmodule

// File: rtl/cfl_ds_pair.sv
module cfl_ds_pair #(
  parameter int unsigned SAMPLE_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                beat,
  input  logic                odd,
  input  logic [SAMPLE_W-1:0] sample,
  output logic [SAMPLE_W:0]   pair_sum
);

  logic [SAMPLE_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            left_q <= '0;
    else if (beat && !odd) left_q <= sample;
  end

  assign pair_sum = {1'b0, left_q} + {1'b0, sample};

endmodule

// File: rtl/cfl_ds_rowbuf.sv
module cfl_ds_rowbuf #(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned DATA_W = 13,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] ent [DEPTH];

  always_ff @(posedge clk) begin
    if (wr) ent[idx] <= wdata;
  end

  assign rdata = ent[idx];

endmodule

// File: rtl/cfl_luma_downsampler.sv
module cfl_luma_downsampler
  import cfl_ds_pkg::*;
#(
  parameter int unsigned SAMPLE_W  = 12,
  parameter int unsigned CONT_W    = 16,
  parameter int unsigned MAX_OUT_W = 32,
  parameter int unsigned BUF_ROWS  = 32,
  localparam int unsigned WORD_W   = CFL_WORD_W,
  localparam int unsigned COL_W    = $clog2(MAX_OUT_W),
  localparam int unsigned ROW_W    = $clog2(BUF_ROWS),
  localparam int unsigned ADDR_W   = COL_W + ROW_W,
  localparam int unsigned WID_W    = COL_W + 1,
  localparam int unsigned HGT_W    = ROW_W + 2,
  localparam int unsigned LCOL_W   = COL_W + 1,
  localparam int unsigned LROW_W   = ROW_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        cfg_fmt,
  input  logic [WID_W-1:0]  cfg_width,
  input  logic [HGT_W-1:0]  cfg_luma_rows,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [CONT_W-1:0] s_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              done,
  output logic              err
);

  logic              beat, at_last;
  logic [LCOL_W-1:0] lcol;
  logic [LROW_W-1:0] lrow;
  cfmt_e             fmt_q;
  logic [WID_W-1:0]  width_q;

  logic [SAMPLE_W-1:0] sample;
  logic                unused_hi;
  logic [SAMPLE_W:0]   pair_sum, top_sum;
  logic [SAMPLE_W+1:0] quad_sum;
  logic                odd, is420, is444;
  logic                store_top, emit;
  logic [COL_W-1:0]    out_col;
  logic [ROW_W-1:0]    out_row;
  logic [WORD_W-1:0]   window_sum, scaled;
  logic                last_wr_q;

  cfl_ds_ctrl #(
    .MAX_OUT_W(MAX_OUT_W), .BUF_ROWS(BUF_ROWS), .WID_W(WID_W),
    .HGT_W(HGT_W), .LCOL_W(LCOL_W), .LROW_W(LROW_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_fmt(cfg_fmt),
    .cfg_width(cfg_width), .cfg_luma_rows(cfg_luma_rows), .s_valid(s_valid),
    .s_ready(s_ready), .beat(beat), .at_last(at_last), .lcol(lcol), .lrow(lrow),
    .fmt_q(fmt_q), .width_q(width_q), .err(err)
  );

  assign sample    = s_data[SAMPLE_W-1:0];
  assign unused_hi = ^s_data[CONT_W-1:SAMPLE_W];

  assign odd   = lcol[0];
  assign is420 = (fmt_q == FMT_420);
  assign is444 = (fmt_q == FMT_444);

  cfl_ds_pair #(.SAMPLE_W(SAMPLE_W)) u_pair (
    .clk(clk), .rst_n(rst_n), .beat(beat), .odd(odd),
    .sample(sample), .pair_sum(pair_sum)
  );

  // Output coordinates: horizontal halving except 4:4:4, vertical only for 4:2:0.
  assign out_col = is444 ? lcol[COL_W-1:0] : lcol[COL_W:1];
  assign out_row = is420 ? lrow[ROW_W:1]   : lrow[ROW_W-1:0];

  // Top-row pair sums of 4:2:0 wait here for their bottom-row partners.
  assign store_top = beat && odd && is420 && !lrow[0];

  cfl_ds_rowbuf #(.DEPTH(MAX_OUT_W), .DATA_W(SAMPLE_W + 1)) u_rowbuf (
    .clk(clk), .wr(store_top), .idx(out_col), .wdata(pair_sum), .rdata(top_sum)
  );

  assign quad_sum = {1'b0, top_sum} + {1'b0, pair_sum};

  assign emit = beat && (is444 || (odd && (!is420 || lrow[0])));

  always_comb begin
    case (fmt_q)
      FMT_420: window_sum = WORD_W'(quad_sum);
      FMT_422: window_sum = WORD_W'(pair_sum);
      default: window_sum = WORD_W'(sample);
    endcase
  end

  assign scaled = scale_word(fmt_q, window_sum);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      last_wr_q <= 1'b0;
      done      <= 1'b0;
    end else begin
      wr_en     <= emit;
      last_wr_q <= beat && at_last;
      done      <= last_wr_q;
      if (emit) begin
        wr_addr <= ADDR_W'(out_row) * ADDR_W'(MAX_OUT_W) + ADDR_W'(out_col);
        wr_data <= scaled;
      end
    end
  end

  a_r1_even_words: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is420) |-> (wr_data[0] == 1'b0));

  a_r2_quad_words: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fmt_q == FMT_422) |-> (wr_data[1:0] == 2'b00));

  a_r3_octal_words: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is444) |-> (wr_data[2:0] == 3'b000));

  a_r4_col_in_width: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ({1'b0, wr_addr[COL_W-1:0]} < width_q));

  a_r5_write_follows_beat: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(beat));

  a_r6_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(wr_en));

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_err_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!wr_en && !done));

  a_r9_msb_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !wr_data[WORD_W-1]);

endmodule

// File: tb/cfl_luma_downsampler_bench.sv
module cfl_luma_downsampler_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [1:0] cfg_fmt;
  logic [5:0] cfg_width;
  logic [6:0] cfg_luma_rows;
  logic       s_valid;
  logic       s_ready;
  logic [15:0] s_data;
  logic       wr_en;
  logic [9:0] wr_addr;
  logic [15:0] wr_data;
  logic       done;
  logic       err;

  always #10 clk = ~clk;

  cfl_luma_downsampler u_cfl_luma_downsampler (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_fmt(cfg_fmt),
    .cfg_width(cfg_width), .cfg_luma_rows(cfg_luma_rows), .s_valid(s_valid),
    .s_ready(s_ready), .s_data(s_data), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .done(done), .err(err)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int wr_count = 0;
  int done_count = 0;
  int last_wr_cyc = 0;
  int done_cyc = 0;
  logic [15:0] mem [0:1023];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (wr_en) begin
      mem[wr_addr] = wr_data;
      wr_count++;
      last_wr_cyc = cyc;
    end
    if (done) begin
      done_count++;
      done_cyc = cyc;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int eff(input int r, input int c, input int seed, input int pat);
    if (pat == 1) return 4095;
    return (r * 131 + c * 29 + seed * 7 + r * c * 3) % 4096;
  endfunction

  function automatic logic [15:0] raw(input int r, input int c, input int seed,
                                      input int pat, input bit junk);
    logic [3:0] hi;
    hi = junk ? 4'((r + c + seed) % 15 + 1) : 4'd0;
    return {hi, 12'(eff(r, c, seed, pat))};
  endfunction

  function automatic int expect_word(input int f, input int r, input int c,
                                     input int seed, input int pat);
    if (f == 0)
      return 2 * (eff(2*r, 2*c, seed, pat) + eff(2*r, 2*c+1, seed, pat) +
                  eff(2*r+1, 2*c, seed, pat) + eff(2*r+1, 2*c+1, seed, pat));
    if (f == 1)
      return 4 * (eff(r, 2*c, seed, pat) + eff(r, 2*c+1, seed, pat));
    return 8 * eff(r, c, seed, pat);
  endfunction

  task automatic clear_log();
    for (int i = 0; i < 1024; i++) mem[i] = 16'hBEEF;
    wr_count   = 0;
    done_count = 0;
  endtask

  task automatic run_case(input int f, input int w, input int h, input int seed,
                          input int pat, input bit junk, input bit stall, input string req);
    int lw, orows, waits, n;
    clear_log();
    lw    = (f == 2) ? w : 2 * w;
    orows = (f == 0) ? h / 2 : h;
    cfg_fmt = 2'(f); cfg_width = 6'(w); cfg_luma_rows = 7'(h);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R7", "err after accepted start", int'(err), 0);
    waits = 0;
    n = 0;
    for (int r = 0; r < h; r++) begin
      for (int c = 0; c < lw; c++) begin
        if (stall && (n % 3 == 2)) begin
          s_valid = 1'b0;
          @(negedge clk);
        end
        s_data  = raw(r, c, seed, pat, junk);
        s_valid = 1'b1;
        while (!s_ready) begin
          waits++;
          @(negedge clk);
        end
        @(negedge clk);
        n++;
      end
    end
    s_valid = 1'b0;
    s_data  = 16'h0;
    chk("R5", "cycles without ready during block", waits, 0);
    repeat (4) @(negedge clk);
    chk("R5", "ready after last sample", int'(s_ready), 0);
    chk("R4", $sformatf("%s write count", req), wr_count, orows * w);
    chk("R6", "done pulses", done_count, 1);
    chk("R6", "done cycle after last write", done_cyc, last_wr_cyc + 1);
    for (int r = 0; r < orows; r++)
      for (int c = 0; c < w; c++)
        chk(req, $sformatf("word row=%0d col=%0d", r, c),
            int'(mem[r * 32 + c]), expect_word(f, r, c, seed, pat));
    if (w < 32) chk("R4", "word past width untouched", int'(mem[w]), 16'hBEEF);
    if (orows < 32) chk("R4", "row past block untouched", int'(mem[orows * 32]), 16'hBEEF);
  endtask

  task automatic run_reject(input int f, input int w, input int h, input string what);
    clear_log();
    cfg_fmt = 2'(f); cfg_width = 6'(w); cfg_luma_rows = 7'(h);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R7", {what, " err raised"}, int'(err), 1);
    chk("R7", {what, " ready low"}, int'(s_ready), 0);
    s_valid = 1'b1;
    s_data  = 16'd123;
    repeat (5) @(negedge clk);
    s_valid = 1'b0;
    chk("R7", {what, " writes"}, wr_count, 0);
    chk("R7", {what, " done pulses"}, done_count, 0);
    chk("R7", {what, " err held"}, int'(err), 1);
  endtask

  task automatic test_reset();
    chk("R10", "wr_en in reset", int'(wr_en), 0);
    chk("R10", "done in reset", int'(done), 0);
    chk("R10", "err in reset", int'(err), 0);
    chk("R10", "s_ready in reset", int'(s_ready), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10", "s_ready after reset", int'(s_ready), 0);
    chk("R10", "wr_en after reset", int'(wr_en), 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; cfg_fmt = 2'd0; cfg_width = 6'd4;
    cfg_luma_rows = 7'd2; s_valid = 1'b0; s_data = 16'h0;
    repeat (3) @(negedge clk);
    test_reset();
    run_case(0, 4, 8, 1, 0, 1'b0, 1'b0, "R1");
    run_case(0, 32, 4, 2, 0, 1'b0, 1'b1, "R1");
    run_case(1, 8, 6, 3, 0, 1'b0, 1'b0, "R2");
    run_case(1, 16, 3, 4, 0, 1'b0, 1'b1, "R2");
    run_case(2, 16, 4, 5, 0, 1'b0, 1'b0, "R3");
    run_case(2, 4, 2, 6, 0, 1'b1, 1'b0, "R8");
    run_case(0, 8, 6, 7, 0, 1'b1, 1'b1, "R8");
    run_case(2, 32, 32, 8, 0, 1'b0, 1'b0, "R3");
    run_case(0, 8, 64, 9, 0, 1'b0, 1'b0, "R4");
    run_case(0, 8, 2, 0, 1, 1'b0, 1'b0, "R9");
    run_case(1, 4, 2, 0, 1, 1'b0, 1'b0, "R9");
    run_case(2, 4, 1, 0, 1, 1'b1, 1'b0, "R9");
    run_reject(3, 8, 4, "format code 3");
    run_reject(0, 12, 4, "width 12");
    run_reject(1, 2, 4, "width 2");
    run_reject(0, 8, 5, "odd rows in 4:2:0");
    run_reject(2, 8, 0, "zero rows");
    run_reject(2, 8, 33, "33 output rows");
    run_reject(0, 63, 4, "width 63");
    run_case(1, 4, 1, 11, 0, 1'b0, 1'b0, "R2");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired R5 actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule